// File: doc/BRIEF.md
# Two-Cycle Byte Processor Core

This block is a small 8-bit load/store processor with separate instruction and data memories. It drives a word address to an instruction memory and takes back 16-bit instruction words. Data moves one byte at a time through a data memory port that has a one-cycle read latency. The core holds four byte-wide registers, and register zero always reads as zero. An ALU serves both register-register and register-immediate operations. Every instruction takes two clock cycles. The first cycle latches the instruction, and the second executes it and writes back the result.

The surrounding system supplies both memories. The instruction memory must answer in the same cycle as its address. The data memory registers its read data on the clock edge. Control flow has three forms: an unconditional jump, a jump taken when a register is zero, and a halt. The halt freezes the core and raises `halted`, and the core stays stopped until the next reset.

Top module: `byte_risc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the core returns to its start state. In that state `imem_addr` is 0, `halted` is 0 and `dmem_we` is 0, every register reads 0, and the first fetch after reset is from word 0.
- R2: Register-form ALU instructions take the opcode in bits 15:12, rd in 11:10, rs1 in 9:8 and rs2 in 7:6. They compute rd = rs1 op rs2 modulo 256, where opcode 0 is add, 1 is sub, 2 is and, 3 is or and 4 is xor.
- R3: Each instruction takes exactly two cycles. `imem_addr` holds through the fetch cycle and changes only at the end of the execute cycle. Every instruction outside the control group moves it forward by one word.
- R4: Opcodes 5 (shl), 6 (shr), 7 (rol) and 8 (ror) move rs1 by the amount in rs2 bits 2:0. The shifts fill with zeros, and the rotates wrap the bits around within 8 bits.
- R5: Immediate opcodes 9 (add), 10 (and), 11 (or) and 12 (xor) compute rd = rd op imm, where imm is bits 7:0. The rs1 field has no effect on these opcodes.
- R6: Store (opcode 15) writes the register selected by bits 11:10 to address rs1 + imm modulo 256. `dmem_we` is high only in the execute cycle of a store.
- R7: Load (opcode 13) places the byte at address rs1 + imm modulo 256 into rd. The address is presented in the fetch cycle, so the one-cycle memory latency is hidden.
- R8: Register r0 reads as zero. ALU results and loads aimed at r0 are discarded.
- R9: Opcode 14 with bits 11:10 = 00 is a jump. It loads the PC with bits 7:0.
- R10: Opcode 14 with bits 11:10 = 01 is a conditional jump. It jumps to bits 7:0 when the register selected by bits 9:8 is zero, and moves forward by one word otherwise.
- R11: Opcode 14 with bits 11:10 = 10 is halt. It holds the PC, raises `halted` until reset and blocks all further memory writes. Opcode 14 with bits 11:10 = 11 does nothing and advances the PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | PC_W (8) | Instruction word address (current PC) |
| imem_data | input | 16 | Instruction word, combinational response to `imem_addr` |
| dmem_addr | output | DATA_W (8) | Data byte address |
| dmem_wdata | output | DATA_W (8) | Byte to store |
| dmem_we | output | 1 | Store strobe, sampled at the rising edge |
| dmem_rdata | input | DATA_W (8) | Read byte, registered by the memory one edge after the address |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A register or memory write becomes visible after the second rising edge that follows the fetch of its instruction. The PC changes only on every second edge, so a program of n instructions ending in halt raises `halted` exactly 2n edges after reset is released. The bench drives and samples on falling edges. It counts those edges to check the per-cycle PC sequence and the total cycle count. It compares memory only once `halted` is seen, and results held in registers are brought out to memory by store instructions. In the halt hold test, the PC and store strobe are sampled on every falling edge over several cycles.

// File: rtl/brc_pkg.sv
package brc_pkg;

   localparam int INSTR_W = 16;
   localparam int OPC_MSB = 15;
   localparam int OPC_LSB = 12;
   localparam int RD_LSB  = 10;
   localparam int RS1_LSB = 8;
   localparam int RS2_LSB = 6;
   localparam int IMM_W   = 8;
   localparam int RIDX_W  = 2;

   typedef enum logic [3:0] {
      OPC_ADD  = 4'h0,
      OPC_SUB  = 4'h1,
      OPC_AND  = 4'h2,
      OPC_OR   = 4'h3,
      OPC_XOR  = 4'h4,
      OPC_SHL  = 4'h5,
      OPC_SHR  = 4'h6,
      OPC_ROL  = 4'h7,
      OPC_ROR  = 4'h8,
      OPC_ADDI = 4'h9,
      OPC_ANDI = 4'hA,
      OPC_ORI  = 4'hB,
      OPC_XORI = 4'hC,
      OPC_LD   = 4'hD,
      OPC_CTL  = 4'hE,
      OPC_ST   = 4'hF
   } opcode_e;

   typedef enum logic [1:0] {
      CTL_JMP  = 2'b00,
      CTL_JZ   = 2'b01,
      CTL_HALT = 2'b10,
      CTL_NOP  = 2'b11
   } ctl_e;

   typedef enum logic [3:0] {
      FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR,
      FN_SHL, FN_SHR, FN_ROL, FN_ROR
   } alu_fn_e;

   typedef enum logic [1:0] {
      PH_FETCH = 2'd0,
      PH_EXEC  = 2'd1,
      PH_HALT  = 2'd2
   } phase_e;

   typedef struct packed {
      alu_fn_e fn;
      logic    use_imm;
      logic    wr_en;
      logic    is_load;
      logic    is_store;
      logic    is_jmp;
      logic    is_jz;
      logic    is_halt;
   } ctrl_t;

endpackage

// File: rtl/brc_decode.sv
module brc_decode
   import brc_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   output ctrl_t              ctrl,
   output logic [RIDX_W-1:0]  rd,
   output logic [RIDX_W-1:0]  rs1,
   output logic [RIDX_W-1:0]  rs2,
   output logic [IMM_W-1:0]   imm
);

   opcode_e opc;
   ctl_e    sub;

   assign opc = opcode_e'(instr[OPC_MSB:OPC_LSB]);
   assign sub = ctl_e'(instr[RD_LSB +: RIDX_W]);
   assign rd  = instr[RD_LSB  +: RIDX_W];
   assign rs1 = instr[RS1_LSB +: RIDX_W];
   assign rs2 = instr[RS2_LSB +: RIDX_W];
   assign imm = instr[IMM_W-1:0];

   always_comb begin
      ctrl          = '0;
      ctrl.fn       = FN_ADD;
      unique case (opc)
         OPC_ADD:  begin ctrl.fn = FN_ADD; ctrl.wr_en = 1'b1; end
         OPC_SUB:  begin ctrl.fn = FN_SUB; ctrl.wr_en = 1'b1; end
         OPC_AND:  begin ctrl.fn = FN_AND; ctrl.wr_en = 1'b1; end
         OPC_OR:   begin ctrl.fn = FN_OR;  ctrl.wr_en = 1'b1; end
         OPC_XOR:  begin ctrl.fn = FN_XOR; ctrl.wr_en = 1'b1; end
         OPC_SHL:  begin ctrl.fn = FN_SHL; ctrl.wr_en = 1'b1; end
         OPC_SHR:  begin ctrl.fn = FN_SHR; ctrl.wr_en = 1'b1; end
         OPC_ROL:  begin ctrl.fn = FN_ROL; ctrl.wr_en = 1'b1; end
         OPC_ROR:  begin ctrl.fn = FN_ROR; ctrl.wr_en = 1'b1; end
         OPC_ADDI: begin ctrl.fn = FN_ADD; ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; end
         OPC_ANDI: begin ctrl.fn = FN_AND; ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; end
         OPC_ORI:  begin ctrl.fn = FN_OR;  ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; end
         OPC_XORI: begin ctrl.fn = FN_XOR; ctrl.wr_en = 1'b1; ctrl.use_imm = 1'b1; end
         OPC_LD:   begin ctrl.is_load = 1'b1; ctrl.wr_en = 1'b1; end
         OPC_ST:   ctrl.is_store = 1'b1;
         OPC_CTL: begin
            unique case (sub)
               CTL_JMP:  ctrl.is_jmp  = 1'b1;
               CTL_JZ:   ctrl.is_jz   = 1'b1;
               CTL_HALT: ctrl.is_halt = 1'b1;
               default:  ;
            endcase
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/brc_alu.sv
module brc_alu
   import brc_pkg::*;
#(
   parameter int W         = 8,
   parameter int ROT_STYLE = 0
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_fn_e      fn,
   output logic [W-1:0] y
);

   localparam int SH_W = $clog2(W);

   logic [SH_W-1:0] amt;
   logic [W-1:0]    rol_y;
   logic [W-1:0]    ror_y;

   assign amt = b[SH_W-1:0];

   if (ROT_STYLE == 0) begin : g_rot_double
      logic [2*W-1:0] dl;
      logic [2*W-1:0] dr;
      assign dl    = {a, a} << amt;
      assign dr    = {a, a} >> amt;
      assign rol_y = dl[2*W-1:W];
      assign ror_y = dr[W-1:0];
   end else begin : g_rot_stages
      logic [W-1:0] sl [SH_W+1];
      logic [W-1:0] sr [SH_W+1];
      assign sl[0] = a;
      assign sr[0] = a;
      for (genvar s = 0; s < SH_W; s++) begin : g_stage
         localparam int K = 1 << s;
         assign sl[s+1] = amt[s] ? {sl[s][W-1-K:0], sl[s][W-1:W-K]} : sl[s];
         assign sr[s+1] = amt[s] ? {sr[s][K-1:0], sr[s][W-1:K]}     : sr[s];
      end
      assign rol_y = sl[SH_W];
      assign ror_y = sr[SH_W];
   end

   always_comb begin
      unique case (fn)
         FN_ADD:  y = a + b;
         FN_SUB:  y = a - b;
         FN_AND:  y = a & b;
         FN_OR:   y = a | b;
         FN_XOR:  y = a ^ b;
         FN_SHL:  y = a << amt;
         FN_SHR:  y = a >> amt;
         FN_ROL:  y = rol_y;
         FN_ROR:  y = ror_y;
         default: y = a;
      endcase
   end

endmodule

// File: rtl/brc_regfile.sv
module brc_regfile #(
   parameter int W  = 8,
   parameter int N  = 4,
   parameter int AW = 2
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr_a,
   input  logic [AW-1:0] raddr_b,
   input  logic [AW-1:0] raddr_c,
   output logic [W-1:0]  rdata_a,
   output logic [W-1:0]  rdata_b,
   output logic [W-1:0]  rdata_c
);

   logic [N-1:0][W-1:0] file;

   // slot zero has no storage: it is a constant zero
   assign file[0] = '0;

   for (genvar i = 1; i < N; i++) begin : g_reg
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (we && (waddr == AW'(i)))
            q <= wdata;
      end
      assign file[i] = q;
   end

   assign rdata_a = file[raddr_a];
   assign rdata_b = file[raddr_b];
   assign rdata_c = file[raddr_c];

endmodule

// File: rtl/byte_risc_core.sv
module byte_risc_core
   import brc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PC_W      = 8,
   parameter int ROT_STYLE = 0
)(
   input  logic               clk,
   input  logic               rst,
   output logic [PC_W-1:0]    imem_addr,
   input  logic [INSTR_W-1:0] imem_data,
   output logic [DATA_W-1:0]  dmem_addr,
   output logic [DATA_W-1:0]  dmem_wdata,
   output logic               dmem_we,
   input  logic [DATA_W-1:0]  dmem_rdata,
   output logic               halted
);

   localparam int NUM_REGS = 1 << RIDX_W;

   if (DATA_W != IMM_W) begin : g_bad_data_w
      $error("byte_risc_core: DATA_W must equal the 8-bit immediate width");
   end
   if (PC_W < IMM_W) begin : g_bad_pc_w
      $error("byte_risc_core: PC_W must hold an 8-bit jump target");
   end
   if (ROT_STYLE < 0 || ROT_STYLE > 1) begin : g_bad_rot
      $error("byte_risc_core: ROT_STYLE must be 0 or 1");
   end

   phase_e               phase_q;
   logic [PC_W-1:0]      pc_q;
   logic [PC_W-1:0]      pc_next;
   logic [INSTR_W-1:0]   ir_q;

   ctrl_t                ctrl;
   logic [RIDX_W-1:0]    dec_rd, dec_rs1, dec_rs2;
   logic [IMM_W-1:0]     dec_imm;

   logic [RIDX_W-1:0]    base_idx;
   logic [DATA_W-1:0]    offset;
   logic [DATA_W-1:0]    reg_a, reg_b, reg_c;
   logic [DATA_W-1:0]    alu_a, alu_b, alu_y;
   logic [DATA_W-1:0]    wb_data;
   logic                 wb_en;
   logic                 in_fetch, in_exec;
   logic                 take_jump;

   assign in_fetch = (phase_q == PH_FETCH);
   assign in_exec  = (phase_q == PH_EXEC);

   brc_decode u_dec (
      .instr (ir_q),
      .ctrl  (ctrl),
      .rd    (dec_rd),
      .rs1   (dec_rs1),
      .rs2   (dec_rs2),
      .imm   (dec_imm)
   );

   // fetch: base register and offset come straight from the arriving word
   assign base_idx = in_fetch ? imem_data[RS1_LSB +: RIDX_W] : dec_rs1;
   assign offset   = in_fetch ? imem_data[IMM_W-1:0]         : dec_imm;

   brc_regfile #(.W(DATA_W), .N(NUM_REGS), .AW(RIDX_W)) u_rf (
      .clk     (clk),
      .rst     (rst),
      .we      (wb_en),
      .waddr   (dec_rd),
      .wdata   (wb_data),
      .raddr_a (base_idx),
      .raddr_b (dec_rs2),
      .raddr_c (dec_rd),
      .rdata_a (reg_a),
      .rdata_b (reg_b),
      .rdata_c (reg_c)
   );

   assign alu_a = ctrl.use_imm ? reg_c   : reg_a;
   assign alu_b = ctrl.use_imm ? dec_imm : reg_b;

   brc_alu #(.W(DATA_W), .ROT_STYLE(ROT_STYLE)) u_alu (
      .a  (alu_a),
      .b  (alu_b),
      .fn (ctrl.fn),
      .y  (alu_y)
   );

   assign wb_data = ctrl.is_load ? dmem_rdata : alu_y;
   assign wb_en   = in_exec && ctrl.wr_en;

   assign dmem_addr  = reg_a + offset;
   assign dmem_wdata = reg_c;
   assign dmem_we    = in_exec && ctrl.is_store;

   assign take_jump = ctrl.is_jmp || (ctrl.is_jz && (reg_a == '0));

   always_comb begin
      if (ctrl.is_halt)
         pc_next = pc_q;
      else if (take_jump)
         pc_next = PC_W'(dec_imm);
      else
         pc_next = pc_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_FETCH;
         pc_q    <= '0;
         ir_q    <= '0;
      end else begin
         unique case (phase_q)
            PH_FETCH: begin
               ir_q    <= imem_data;
               phase_q <= PH_EXEC;
            end
            PH_EXEC: begin
               pc_q    <= pc_next;
               phase_q <= ctrl.is_halt ? PH_HALT : PH_FETCH;
            end
            default: ;
         endcase
      end
   end

   assign imem_addr = pc_q;
   assign halted    = (phase_q == PH_HALT);

endmodule

// File: rtl/brc_checker.sv
module brc_checker
   import brc_pkg::*;
#(
   parameter int PC_W = 8
)(
   input logic               clk,
   input logic               rst,
   input logic [1:0]         phase,
   input logic [INSTR_W-1:0] ir,
   input logic [PC_W-1:0]    pc,
   input logic               halted,
   input logic               dmem_we
);

   AST_FETCH_PC_STABLE: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_FETCH) |=> $stable(pc)); // R3

   AST_EXEC_LEAVES: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC) |=> (phase != PH_EXEC)); // R3

   AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && ir[OPC_MSB:OPC_LSB] != OPC_CTL)
      |=> (pc == PC_W'($past(pc) + 1'b1))); // R3

   AST_STORE_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (phase == PH_EXEC && ir[OPC_MSB:OPC_LSB] == OPC_ST)); // R6

   AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_EXEC && ir[OPC_MSB:OPC_LSB] == OPC_CTL && ir[11:10] == CTL_JMP)
      |=> (pc == PC_W'($past(ir[7:0])))); // R9

   AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
      halted |=> (halted && $stable(pc) && !dmem_we)); // R11

endmodule

bind byte_risc_core brc_checker #(.PC_W(PC_W)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .phase   (phase_q),
   .ir      (ir_q),
   .pc      (pc_q),
   .halted  (halted),
   .dmem_we (dmem_we)
);

// File: tb/sim_byte_risc_core.sv
module sim_byte_risc_core;

   localparam logic [3:0] O_ADD = 4'h0, O_SUB = 4'h1, O_AND = 4'h2, O_OR = 4'h3, O_XOR = 4'h4;
   localparam logic [3:0] O_SHL = 4'h5, O_SHR = 4'h6, O_ROL = 4'h7, O_ROR = 4'h8;
   localparam logic [3:0] O_ADDI = 4'h9, O_ANDI = 4'hA, O_ORI = 4'hB, O_XORI = 4'hC;
   localparam logic [3:0] O_LD = 4'hD, O_CTL = 4'hE, O_ST = 4'hF;

   // {opcode, rs1 value, rs2 value, expected rd}
   localparam int NVEC = 12;
   localparam logic [27:0] VEC [NVEC] = '{
      {O_ADD, 8'h7F, 8'h01, 8'h80},
      {O_ADD, 8'hFF, 8'h02, 8'h01},
      {O_SUB, 8'h05, 8'h07, 8'hFE},
      {O_AND, 8'hF0, 8'h3C, 8'h30},
      {O_OR,  8'hF0, 8'h0C, 8'hFC},
      {O_XOR, 8'hAA, 8'hFF, 8'h55},
      {O_SHL, 8'h81, 8'h03, 8'h08},
      {O_SHR, 8'h81, 8'h03, 8'h10},
      {O_ROL, 8'h81, 8'h03, 8'h0C},
      {O_ROR, 8'h81, 8'h01, 8'hC0},
      {O_SHL, 8'h81, 8'h0B, 8'h08},
      {O_ROR, 8'h5A, 8'h08, 8'h5A}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  imem_addr;
   logic [15:0] imem_data;
   logic [7:0]  dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we, halted;

   logic [15:0] imem [256];
   logic [7:0]  dmem [256];

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   byte_risc_core u0 (
      .clk(clk), .rst(rst),
      .imem_addr(imem_addr), .imem_data(imem_data),
      .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
      .dmem_rdata(dmem_rdata), .halted(halted)
   );

   assign imem_data = imem[imem_addr];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
      dmem_rdata <= dmem[dmem_addr];
   end

   function automatic logic [15:0] rr(logic [3:0] op, logic [1:0] rd, logic [1:0] rs1, logic [1:0] rs2);
      return {op, rd, rs1, rs2, 6'b0};
   endfunction

   function automatic logic [15:0] ri(logic [3:0] op, logic [1:0] rd, logic [1:0] rs1, logic [7:0] imm);
      return {op, rd, rs1, imm};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mems();
      for (int i = 0; i < 256; i++) begin
         imem[i] = ri(O_CTL, 2'b10, 2'd0, 8'h00);
         dmem[i] = 8'hEE;
      end
   endtask

   task automatic start();
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      @(negedge clk) rst = 1'b0;
   endtask

   task automatic wait_halt(output int cyc);
      cyc = 0;
      while (halted !== 1'b1 && cyc < 400) begin
         @(negedge clk);
         cyc++;
      end
      check("R11 halted raised", 32'(halted), 32'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int cyc;
      logic [7:0] hold_pc;
      int we_seen;

      // register-form vectors
      for (int v = 0; v < NVEC; v++) begin
         logic [3:0] op;
         logic [7:0] va, vb, ve;
         op = VEC[v][27:24];
         va = VEC[v][23:16];
         vb = VEC[v][15:8];
         ve = VEC[v][7:0];
         clear_mems();
         imem[0] = ri(O_ADDI, 2'd1, 2'd0, va);
         imem[1] = ri(O_ADDI, 2'd2, 2'd0, vb);
         imem[2] = rr(op, 2'd3, 2'd1, 2'd2);
         imem[3] = ri(O_ST, 2'd3, 2'd0, 8'h80);
         start();
         wait_halt(cyc);
         check((op >= O_SHL) ? "R4 shift/rotate" : "R2 register ALU", 32'(dmem[8'h80]), 32'(ve));
         if (v == 0) begin
            check("R3 five instructions take ten cycles", 32'(cyc), 32'd10);
            check("R11 halt holds pc", 32'(imem_addr), 32'd4);
         end
      end

      // immediate forms, R5; also per-cycle PC sequence, R3
      clear_mems();
      imem[0] = ri(O_ADDI, 2'd1, 2'd0, 8'h0F);
      imem[1] = ri(O_ORI,  2'd1, 2'd0, 8'hF0);
      imem[2] = ri(O_ANDI, 2'd1, 2'd0, 8'h3C);
      imem[3] = ri(O_XORI, 2'd1, 2'd0, 8'hFF);
      imem[4] = ri(O_ST,   2'd1, 2'd0, 8'h20);
      imem[5] = ri(O_ADDI, 2'd2, 2'd1, 8'h05);
      imem[6] = ri(O_ST,   2'd2, 2'd0, 8'h21);
      start();
      check("R1 first fetch at word 0", 32'(imem_addr), 32'd0);
      @(negedge clk);
      check("R3 pc held in fetch", 32'(imem_addr), 32'd0);
      @(negedge clk);
      check("R3 pc advanced after execute", 32'(imem_addr), 32'd1);
      @(negedge clk);
      check("R3 pc held in second fetch", 32'(imem_addr), 32'd1);
      @(negedge clk);
      check("R3 pc advanced again", 32'(imem_addr), 32'd2);
      wait_halt(cyc);
      check("R5 addi/ori/andi/xori chain", 32'(dmem[8'h20]), 32'hC3);
      check("R5 rs1 field ignored by immediate add", 32'(dmem[8'h21]), 32'h05);

      // halt hold over several cycles, R11
      hold_pc = imem_addr;
      we_seen = 0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         if (dmem_we) we_seen++;
      end
      check("R11 pc frozen after halt", 32'(imem_addr), 32'(hold_pc));
      check("R11 halted stays high", 32'(halted), 32'd1);
      check("R11 no store after halt", 32'(we_seen), 32'd0);

      // reset state with r1=C3, r2=05 held from the program above, R1
      @(negedge clk) rst = 1'b1;
      @(negedge clk);
      check("R1 reset pc", 32'(imem_addr), 32'd0);
      check("R1 reset halted", 32'(halted), 32'd0);
      check("R1 reset store strobe", 32'(dmem_we), 32'd0);
      clear_mems();
      imem[0] = ri(O_ST, 2'd1, 2'd0, 8'h50);
      imem[1] = ri(O_ST, 2'd2, 2'd0, 8'h51);
      imem[2] = ri(O_ST, 2'd3, 2'd0, 8'h52);
      start();
      wait_halt(cyc);
      check("R1 r1 cleared", 32'(dmem[8'h50]), 32'd0);
      check("R1 r2 cleared", 32'(dmem[8'h51]), 32'd0);
      check("R1 r3 cleared", 32'(dmem[8'h52]), 32'd0);

      // load/store with wrapping address and r0 writes
      clear_mems();
      imem[0]  = ri(O_ADDI, 2'd1, 2'd0, 8'hF0);
      imem[1]  = ri(O_ADDI, 2'd2, 2'd0, 8'h77);
      imem[2]  = ri(O_ST,   2'd2, 2'd1, 8'h20);
      imem[3]  = ri(O_LD,   2'd3, 2'd0, 8'h10);
      imem[4]  = ri(O_ADDI, 2'd3, 2'd0, 8'h01);
      imem[5]  = ri(O_ST,   2'd3, 2'd1, 8'h40);
      imem[6]  = ri(O_LD,   2'd0, 2'd0, 8'h10);
      imem[7]  = ri(O_ST,   2'd0, 2'd1, 8'h50);
      imem[8]  = ri(O_ADDI, 2'd0, 2'd0, 8'h55);
      imem[9]  = ri(O_ST,   2'd0, 2'd0, 8'h41);
      start();
      wait_halt(cyc);
      check("R6 store to wrapped address", 32'(dmem[8'h10]), 32'h77);
      check("R6 unwrapped address untouched", 32'(dmem[8'h20]), 32'hEE);
      check("R7 loaded byte reaches rd", 32'(dmem[8'h30]), 32'h78);
      check("R8 load into r0 discarded", 32'(dmem[8'h40]), 32'h00);
      check("R8 addi into r0 discarded", 32'(dmem[8'h41]), 32'h00);

      // control flow
      clear_mems();
      imem[0]  = ri(O_ADDI, 2'd1, 2'd0, 8'h01);
      imem[1]  = ri(O_CTL,  2'b01, 2'd1, 8'd6);
      imem[2]  = ri(O_CTL,  2'b11, 2'd0, 8'd0);
      imem[3]  = ri(O_CTL,  2'b01, 2'd0, 8'd5);
      imem[4]  = ri(O_ADDI, 2'd2, 2'd0, 8'h11);
      imem[5]  = ri(O_CTL,  2'b00, 2'd0, 8'd7);
      imem[6]  = ri(O_ADDI, 2'd2, 2'd0, 8'h22);
      imem[7]  = ri(O_ADDI, 2'd3, 2'd0, 8'h33);
      imem[8]  = ri(O_ST,   2'd3, 2'd0, 8'h41);
      imem[9]  = ri(O_ST,   2'd2, 2'd0, 8'h40);
      start();
      wait_halt(cyc);
      check("R10 jz taken and not taken, R9 jmp skip", 32'(dmem[8'h40]), 32'h00);
      check("R9 jmp target executes", 32'(dmem[8'h41]), 32'h33);
      check("R11 nop advances, nine instructions", 32'(cyc), 32'd18);
      check("R11 halt address", 32'(imem_addr), 32'd10);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule